// File: doc/BRIEF.md
# Transmit IP Header Validity Checker

This block watches an outgoing Ethernet frame as a byte stream and decides, by the time the frame's last byte goes by, whether its IP header is consistent. The application marks the first and last byte of each frame. It also raises a header-end sideband on the last byte of the IP header. The checker reads the Length/Type field and the version and header-length nibbles. It counts the header bytes that were really supplied and compares that count with what the header declares and with what the frame type requires.

The result is a header-error pulse on the frame's final beat. A summary error on the same beat combines the header error with a payload-error input and a vector of other per-frame transmit error inputs. Frames that carry neither IPv4 (0x0800) nor IPv6 (0x86DD) are not inspected. The block only observes the stream and does not alter it.

Top module: `tx_iphdr_check`

## Requirements
- R1: Byte positions count from 0 at the start beat. Bytes 12 and 13 hold Length/Type, high byte first. Byte 14 carries the version in bits 7:4 and the IPv4 header length (in 32-bit words) in bits 3:0. Header bytes are counted from byte 14 up to and including the first beat at position 14 or later with the header-end sideband high. For Length/Type 0x0800, a header error is flagged when four times the header-length nibble differs from that count.
- R2: For Length/Type 0x0800, a header error is flagged when the header-length nibble is below 5.
- R3: For Length/Type 0x86DD, a header error is flagged when the counted header is not exactly 40 bytes.
- R4: A header error is flagged when Length/Type is 0x0800 and the version is not 4, or when Length/Type is 0x86DD and the version is not 6.
- R5: A frame is never flagged if its Length/Type is any other value, or if it ends before byte 14.
- R6: `hdr_err` is high only on the valid end beat of a flagged frame, for that single cycle.
- R7: `err_sum` is high on a valid end beat exactly when `hdr_err`, `pay_err` or any bit of `oth_err` is high on that beat, and it is low on every other cycle.
- R8: An IPv4 or IPv6 frame that reaches byte 14 but ends without any header-end beat at position 14 or later is flagged as a header error.
- R9: While `rst_n` is low, both outputs are low.
- R10: Header-end marks before byte 14, and any after the first counted one, have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Byte beat valid |
| in_data | input | 8 | Frame byte |
| in_start | input | 1 | First byte of frame |
| in_end | input | 1 | Last byte of frame |
| in_hdr_end | input | 1 | Last byte of the IP header |
| pay_err | input | 1 | Payload error of the frame, sampled on the end beat |
| oth_err | input | OTH_W | Other per-frame transmit errors, sampled on the end beat |
| hdr_err | output | 1 | IP header error, on the end beat |
| err_sum | output | 1 | Summary error, on the end beat |

## Verification
On every cycle, the assertions check the following. Both outputs stay low outside end beats and during reset. The summary covers the header error and the payload error. A single-beat frame is never flagged. The decision itself needs known frame contents, so only the bench scenarios can show it: declared versus delivered length, a short header-length nibble, the IPv6 fixed length, a type/version mismatch, truncated frames, ignored non-IP frames and surplus header-end marks. Each scenario predicts the expected pair of outputs for its frame, and the monitor compares that pair on the end beat.

// File: rtl/tx_iphdr_check.sv
module tx_iphdr_check #(
  parameter int OTH_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_start,
  input  logic             in_end,
  input  logic             in_hdr_end,
  input  logic             pay_err,
  input  logic [OTH_W-1:0] oth_err,
  output logic             hdr_err,
  output logic             err_sum
);
  localparam logic [CNT_W-1:0] CMAX   = '1;
  localparam logic [CNT_W-1:0] IP_OFS = CNT_W'(14);
  localparam logic [CNT_W-1:0] V6_LEN = CNT_W'(40);

  logic [CNT_W-1:0] pos_q, hcnt_q;
  logic [15:0]      etype_q;
  logic [3:0]       ver_q, ihl_q;
  logic             done_q, bad_q;

  wire [CNT_W-1:0] pos_c  = in_start ? '0 : pos_q;
  wire [CNT_W-1:0] hcnt_c = in_start ? '0 : hcnt_q;
  wire             done_c = in_start ? 1'b0 : done_q;
  wire             bad_c  = in_start ? 1'b0 : bad_q;

  wire in_ip    = pos_c >= IP_OFS;
  wire first_ip = pos_c == IP_OFS;
  wire [3:0] ver_c = first_ip ? in_data[7:4] : ver_q;
  wire [3:0] ihl_c = first_ip ? in_data[3:0] : ihl_q;
  wire [CNT_W-1:0] hcnt_n = (hcnt_c == CMAX) ? hcnt_c : hcnt_c + 1'b1;
  wire [CNT_W-1:0] pos_n  = (pos_c == CMAX) ? pos_c : pos_c + 1'b1;

  wire is4 = etype_q == 16'h0800;
  wire is6 = etype_q == 16'h86DD;

  logic bad_now;
  always_comb begin
    bad_now = 1'b0;
    if (is4)
      bad_now = (ver_c != 4'd4) || (ihl_c < 4'd5) || (CNT_W'({ihl_c, 2'b00}) != hcnt_n);
    else if (is6)
      bad_now = (ver_c != 4'd6) || (hcnt_n != V6_LEN);
  end

  wire hdr_beat = in_valid && in_hdr_end && in_ip && !done_c;
  wire end_beat = rst_n && in_valid && in_end;
  wire checked  = in_ip && (is4 || is6);

  assign hdr_err = end_beat && checked && (done_c ? bad_c : (hdr_beat ? bad_now : 1'b1));
  assign err_sum = hdr_err || (end_beat && (pay_err || |oth_err));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      hcnt_q  <= '0;
      etype_q <= '0;
      ver_q   <= '0;
      ihl_q   <= '0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else if (in_valid) begin
      pos_q  <= pos_n;
      hcnt_q <= (in_ip && !done_c) ? hcnt_n : hcnt_c;
      done_q <= done_c || hdr_beat;
      bad_q  <= hdr_beat ? bad_now : bad_c;
      if (pos_c == CNT_W'(12)) etype_q[15:8] <= in_data;
      if (pos_c == CNT_W'(13)) etype_q[7:0]  <= in_data;
      if (first_ip) begin
        ver_q <= in_data[7:4];
        ihl_q <= in_data[3:0];
      end
    end
  end
endmodule

module tx_iphdr_check_sva #(
  parameter int OTH_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_start,
  input logic             in_end,
  input logic             pay_err,
  input logic [OTH_W-1:0] oth_err,
  input logic             hdr_err,
  input logic             err_sum
);
  assert_pulse_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> (in_valid && in_end));
  assert_quiet_off_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_end) |-> !err_sum);
  assert_sum_has_hdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> err_sum);
  assert_sum_has_pay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_end && (pay_err || |oth_err)) |-> err_sum);
  assert_one_beat_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start && in_end) |-> !hdr_err);
  assert_reset_low_R9: assert property (@(posedge clk)
    !rst_n |-> (!hdr_err && !err_sum));
endmodule

bind tx_iphdr_check tx_iphdr_check_sva #(.OTH_W(OTH_W)) sva_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
  .in_end(in_end), .pay_err(pay_err), .oth_err(oth_err),
  .hdr_err(hdr_err), .err_sum(err_sum)
);

// File: tb/tx_iphdr_check_tb.sv
module tx_iphdr_check_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0, in_hdr_end = 1'b0, pay_err = 1'b0;
  logic [7:0] in_data = '0;
  logic [3:0] oth_err = '0;
  logic hdr_err, err_sum;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  tx_iphdr_check #(.OTH_W(4), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_start(in_start), .in_end(in_end), .in_hdr_end(in_hdr_end),
    .pay_err(pay_err), .oth_err(oth_err), .hdr_err(hdr_err), .err_sum(err_sum)
  );

  task automatic send(input string rq, input logic [15:0] et, input logic [3:0] ver,
                      input logic [3:0] ihl, input int nhdr, input int len, input bit pay,
                      input logic [3:0] oth, input int dup, input bit gap);
    bit ip4 = (et == 16'h0800);
    bit ip6 = (et == 16'h86DD);
    bit eh;
    if (!(ip4 || ip6) || len < 15) eh = 1'b0;
    else if (nhdr == 0 || 13 + nhdr > len - 1) eh = 1'b1;
    else if (ip4) eh = (ver != 4) || (ihl < 5) || (int'(ihl) * 4 != nhdr);
    else eh = (ver != 6) || (nhdr != 40);
    exp_q.push_back({eh, eh || pay || (oth != 0)});
    tag_q.push_back(rq);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      in_valid   = 1'b1;
      in_start   = (i == 0);
      in_end     = (i == len - 1);
      in_hdr_end = (nhdr > 0 && i == 13 + nhdr) || (dup > 0 && i == dup);
      in_data    = (i == 12) ? et[15:8] : (i == 13) ? et[7:0] : (i == 14) ? {ver, ihl} : 8'(i);
      pay_err    = (i == len - 1) ? pay : 1'b0;
      oth_err    = (i == len - 1) ? oth : 4'd0;
      if (gap && (i % 3 == 1)) begin
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_end = 1'b0;
        in_hdr_end = 1'b0;
        pay_err = 1'b0;
        oth_err = '0;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0; in_hdr_end = 1'b0;
    pay_err = 1'b0; oth_err = '0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      checks++;
      if (hdr_err || err_sum) begin
        fails++;
        $display("FAIL R9 reset outputs act=%b%b exp=00", hdr_err, err_sum);
      end
    end else if (in_valid && in_end) begin
      logic [1:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6 unexpected end beat act=%b%b exp=none", hdr_err, err_sum);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({hdr_err, err_sum} !== e) begin
          fails++;
          $display("FAIL %s hdr_err/err_sum act=%b%b exp=%b", t, hdr_err, err_sum, e);
        end
      end
    end else begin
      checks++;
      if (hdr_err || err_sum) begin
        fails++;
        $display("FAIL R6 output off end beat act=%b%b exp=00", hdr_err, err_sum);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    send("R1 ipv4 match",        16'h0800, 4, 5, 20, 60, 0, 0, 0, 0);
    send("R1 ipv4 mismatch",     16'h0800, 4, 6, 20, 60, 0, 0, 0, 0);
    send("R1 ipv4 ihl6 gaps",    16'h0800, 4, 6, 24, 64, 0, 0, 0, 1);
    send("R2 ipv4 ihl4",         16'h0800, 4, 4, 16, 50, 0, 0, 0, 0);
    send("R3 ipv6 forty",        16'h86DD, 6, 0, 40, 80, 0, 0, 0, 0);
    send("R3 ipv6 short",        16'h86DD, 6, 0, 36, 80, 0, 0, 0, 1);
    send("R4 0800 ver6",         16'h0800, 6, 5, 20, 60, 0, 0, 0, 0);
    send("R4 86DD ver4",         16'h86DD, 4, 0, 40, 80, 0, 0, 0, 0);
    send("R5 arp bad fields",    16'h0806, 4, 4, 3, 42, 0, 0, 0, 0);
    send("R5 non-ip no marker",  16'h88CC, 6, 0, 0, 30, 0, 0, 0, 0);
    send("R5 one beat",          16'h0800, 4, 5, 0, 1, 0, 0, 0, 0);
    send("R5 ends at byte 13",   16'h0800, 4, 5, 0, 14, 0, 0, 0, 0);
    send("R8 ipv4 no marker",    16'h0800, 4, 5, 0, 40, 0, 0, 0, 0);
    send("R8 marker past end",   16'h0800, 4, 5, 20, 30, 0, 0, 0, 0);
    send("R8 ends at byte 14",   16'h0800, 4, 5, 0, 15, 0, 0, 0, 0);
    send("R1 marker on end",     16'h0800, 4, 5, 20, 34, 0, 0, 0, 0);
    send("R7 payload error",     16'h0800, 4, 5, 20, 60, 1, 0, 0, 0);
    send("R7 other error",       16'h86DD, 6, 0, 40, 70, 0, 4'b0100, 0, 0);
    send("R7 hdr and payload",   16'h0800, 4, 7, 20, 60, 1, 4'b0001, 0, 0);
    send("R10 extra late marker",16'h0800, 4, 5, 20, 60, 0, 0, 45, 0);
    send("R10 early marker",     16'h0800, 4, 5, 20, 60, 0, 0, 5, 0);
    send("R10 early marker v6",  16'h86DD, 6, 0, 40, 70, 0, 0, 9, 1);
    repeat (4) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R6 missing end results act=%0d exp=0", exp_q.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule